// File: doc/BRIEF.md
# Dual-Parity Stripe Syndrome Generator

This block produces the two redundancy words of a dual-parity disk stripe. Data words enter one disk at a time on a valid/ready stream. Each word is a 64-bit beat made of eight byte lanes that do not affect one another. The beat of disk 0 carries a last flag. The word P is the XOR of all data words. The word Q is a Reed-Solomon style syndrome over GF(2^8): each disk word is weighted by a power of the generator 2, and the field uses the reduction polynomial 0x11D.

The stream must deliver the disks in descending index order, so the first beat comes from the highest-numbered data disk. That beat seeds both accumulators. For each later beat, Q is first doubled in GF(2^8), one byte at a time, and then XORed with the new word. P is only XORed with the word. When the beat of disk 0 is taken, P and Q are registered together and offered on the output handshake. The input is stalled only while a result waits that is not being accepted in the same cycle. The parameter BEATS widens the datapath to several independent 64-bit beats. Each beat then has its own accumulator pair, and all pairs update in lockstep.

Top module: `pq_syndrome_gen`

## Requirements
- R1: While reset is high, and on the cycle after it, out_valid is 0 and in_ready is 1. The next accepted beat is treated as the first beat of a stripe.
- R2: out_p equals the bitwise XOR of every data word of the stripe.
- R3: out_q equals the GF(2^8) sum over i of 2^i times the word of disk i, computed in each byte lane with polynomial 0x11D. Disk i is the i-th beat counted backwards from the beat that has in_last set, so the last beat is disk 0.
- R4: Doubling works on each byte lane on its own. Bits 7:0 form lane 0. The byte shifts left by one with no carry into the next lane. If the lane's bit 7 was set before the shift, the result is XORed with 0x1D.
- R5: A stripe made of one beat, with in_last set on its first beat, gives out_p = out_q = that word.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and no input beat is consumed.
- R7: While out_valid is 1 and out_ready is 0, out_p and out_q hold their values and out_valid stays 1.
- R8: If the output is accepted in the same cycle as the last beat of the next stripe, out_valid stays 1 in the following cycle and carries the new stripe's result.
- R9: The first beat after a completed stripe seeds both accumulators afresh. No state carries over from the previous stripe.
- R10: out_valid is 1 in the cycle that follows the acceptance of a beat with in_last set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 64*BEATS | Data word of the current disk |
| in_last | input | 1 | The beat belongs to disk 0 |
| out_valid | output | 1 | P/Q result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | 64*BEATS | XOR parity word |
| out_q | output | 64*BEATS | GF(2^8) syndrome word |

## Verification
Two things can happen in the same cycle: the result held at the output is handed off, and the last beat of the following stripe is accepted. In that cycle the output register is refilled at the moment it empties. The bench provokes this by holding out_ready low until a result is waiting and a new single-beat stripe is already presented. It then raises out_ready so that both handshakes meet on one edge. The scoreboard must then see both results, in order and without a gap in out_valid, and the bench counts how many such meetings occur.

// File: rtl/pq_syn_pkg.sv
package pq_syn_pkg;
  localparam int LANE_W = 8;
  localparam int BEAT_LANES = 8;
  localparam int BEAT_W = LANE_W * BEAT_LANES;
  localparam logic [LANE_W-1:0] RED_POLY = 8'h1D;

  // multiply one byte by the generator 2: sign test gives the reduction mask
  function automatic logic [LANE_W-1:0] gf_x2(input logic [LANE_W-1:0] b);
    logic [LANE_W-1:0] neg_mask;
    neg_mask = {LANE_W{b[LANE_W-1]}};
    return {b[LANE_W-2:0], 1'b0} ^ (neg_mask & RED_POLY);
  endfunction
endpackage

// File: rtl/pq_gf_dbl.sv
module pq_gf_dbl
  import pq_syn_pkg::*;
#(
  parameter int LANES = BEAT_LANES
) (
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*LANE_W +: LANE_W] = gf_x2(din[g*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/pq_beat_acc.sv
module pq_beat_acc
  import pq_syn_pkg::*;
#(
  parameter int LANES = BEAT_LANES,
  localparam int W = LANES * LANE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic         seed,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt_p,
  output logic [W-1:0] nxt_q
);
  logic [W-1:0] acc_p, acc_q, q_dbl;

  pq_gf_dbl #(.LANES(LANES)) u_dbl (.din(acc_q), .dout(q_dbl));

  assign nxt_p = seed ? din : (acc_p ^ din);
  assign nxt_q = seed ? din : (q_dbl ^ din);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_p <= '0;
      acc_q <= '0;
    end else if (take) begin
      acc_p <= nxt_p;
      acc_q <= nxt_q;
    end
  end

  // R9: a seeding beat overwrites both accumulators with the word itself
  assert_reseed_R9: assert property (@(posedge clk) disable iff (rst)
    take && seed |=> (acc_p == $past(din)) && (acc_q == $past(din)));
endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen
  import pq_syn_pkg::*;
#(
  parameter int BEATS = 1,
  localparam int DW = BEATS * BEAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_p,
  output logic [DW-1:0] out_q
);
  logic          first_q;
  logic          in_fire, out_fire, stripe_done;
  logic [DW-1:0] nxt_p, nxt_q;

  assign in_ready    = !out_valid || out_ready;
  assign in_fire     = in_valid && in_ready;
  assign out_fire    = out_valid && out_ready;
  assign stripe_done = in_fire && in_last;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    pq_beat_acc #(.LANES(BEAT_LANES)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .take  (in_fire),
      .seed  (first_q),
      .din   (in_data[b*BEAT_W +: BEAT_W]),
      .nxt_p (nxt_p[b*BEAT_W +: BEAT_W]),
      .nxt_q (nxt_q[b*BEAT_W +: BEAT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q   <= 1'b1;
      out_valid <= 1'b0;
      out_p     <= '0;
      out_q     <= '0;
    end else begin
      if (in_fire) first_q <= in_last;
      if (stripe_done) begin
        out_valid <= 1'b1;
        out_p     <= nxt_p;
        out_q     <= nxt_q;
      end else if (out_fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready);
  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_p) && $stable(out_q));
  assert_emit_R10: assert property (@(posedge clk) disable iff (rst)
    stripe_done |=> out_valid);
  assert_single_R5: assert property (@(posedge clk) disable iff (rst)
    stripe_done && first_q |=> out_p == out_q);
  assert_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    stripe_done && out_fire |=> out_valid);
endmodule

// File: tb/pq_syndrome_gen_tb.sv
module pq_syndrome_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_p, out_q;

  typedef struct {
    logic [63:0] p;
    logic [63:0] q;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] words[16];
  int          n_chk = 0, n_fail = 0, collisions = 0;
  int          ready_mode = 1;
  bit          done = 0;

  always #5 clk = ~clk;

  pq_syndrome_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // bit-serial field multiply, full 9-bit polynomial 0x11D
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] aa;
    logic [7:0] r;
    aa = {1'b0, a};
    r = 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= aa[7:0];
      aa = aa << 1;
      if (aa[8]) aa ^= 9'h11D;
    end
    return r;
  endfunction

  function automatic logic [7:0] gpow2(input int e);
    logic [7:0] x;
    x = 8'h01;
    for (int k = 0; k < e; k++) x = gmul(x, 8'h02);
    return x;
  endfunction

  function automatic logic [63:0] scale(input logic [7:0] c, input logic [63:0] w);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[l*8 +: 8] = gmul(c, w[l*8 +: 8]);
    return r;
  endfunction

  task automatic send_words(input int n, input string tag, input bit gaps);
    logic [63:0] p, q;
    p = '0;
    q = '0;
    for (int i = 0; i < n; i++) begin
      p ^= words[i];
      q ^= scale(gpow2(i), words[i]);
    end
    sb.push_back('{p, q, tag});
    for (int d = n - 1; d >= 0; d--) begin
      if (gaps) while ($urandom_range(0, 2) == 0) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = words[d];
      in_last  = (d == 0);
      #3;
      while (!in_ready) begin
        @(negedge clk);
        #3;
      end
      if (in_last && out_valid && out_ready) collisions++;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  // monitor: drives out_ready, pops and compares on every output handshake
  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: out_ready = ($urandom_range(0, 3) != 0);
        1: out_ready = 1'b0;
        default: out_ready = 1'b1;
      endcase
      #3;
      if (!rst && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 unexpected result", out_p, '0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_p == e.p, {e.tag, " P (R2)"}, out_p, e.p);
          chk(out_q == e.q, {e.tag, " Q (R3)"}, out_q, e.q);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", '0, '0);
      finish_run();
    end
  end

  initial begin
    logic [63:0] rec;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    #3;
    chk(!out_valid, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk(in_ready, "R1 in_ready", {63'd0, in_ready}, 64'd1);

    // R5 single-beat stripe, R10 latency
    words[0] = 64'h0123_4567_89AB_CDEF;
    send_words(1, "R5", 0);
    chk(out_valid, "R10 valid after last", {63'd0, out_valid}, 64'd1);
    chk(out_p == out_q, "R5 P equals Q", out_q, out_p);
    chk(out_q == 64'h0123_4567_89AB_CDEF, "R5 word", out_q, 64'h0123_4567_89AB_CDEF);

    // R6/R7 stall, then R8 overlap when out_ready rises
    rec = out_p;
    words[0] = 64'hDEAD_BEEF_0BAD_F00D;
    fork
      send_words(1, "R8", 0);
      begin
        repeat (4) @(negedge clk);
        #3;
        chk(!in_ready, "R6 in_ready low", {63'd0, in_ready}, 64'd0);
        chk(in_valid, "R6 beat still pending", {63'd0, in_valid}, 64'd1);
        chk(out_p == rec, "R7 out_p held", out_p, rec);
        chk(out_valid, "R7 out_valid held", {63'd0, out_valid}, 64'd1);
        ready_mode = 2;
      end
    join
    chk(out_valid, "R8 valid kept", {63'd0, out_valid}, 64'd1);
    chk(out_p == 64'hDEAD_BEEF_0BAD_F00D, "R8 new result", out_p, 64'hDEAD_BEEF_0BAD_F00D);

    // R4 lane doubling with known values: lane bytes FF,01,40,80,C3,00,7F,80
    words[1] = 64'hFF01_4080_C300_7F80;
    words[0] = 64'h0;
    send_words(2, "R4", 0);
    chk(out_q == 64'hE302_801D_9B00_FE1D, "R4 doubled Q", out_q, 64'hE302_801D_9B00_FE1D);
    chk(out_p == 64'hFF01_4080_C300_7F80, "R4 P", out_p, 64'hFF01_4080_C300_7F80);

    // R2 equal words cancel in P
    words[0] = 64'h5A5A_1234_FFFF_0001;
    words[1] = 64'h5A5A_1234_FFFF_0001;
    send_words(2, "R2", 0);
    chk(out_p == 64'd0, "R2 cancel", out_p, 64'd0);

    // R9 back-to-back stripes with no gaps
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 16; i++) words[i] = {$urandom, $urandom};
      send_words(3 + s, "R9", 0);
    end

    // R3 random stripes with random stalls on both sides
    ready_mode = 0;
    for (int s = 0; s < 40; s++) begin
      int n;
      n = $urandom_range(1, 16);
      for (int i = 0; i < 16; i++) words[i] = {$urandom, $urandom};
      send_words(n, "R3", 1);
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(collisions > 0, "R8 overlap seen", 64'(collisions), 64'd1);
    done = 1;
    finish_run();
  end
endmodule